// File: doc/BRIEF.md
# Pipelined FIR Filter with Selectable Product Summation

This block is a direct-form FIR filter for signed two's-complement samples and compile-time signed coefficients. Each accepted sample moves down a tap delay line. Every tap is multiplied by its own coefficient, and the products are added at full precision. No rounding and no saturation are applied.

A compile-time parameter sets how the products are added:

- a linear chain of adders;
- a combinational pairwise tree;
- a pairwise tree with a register after every level.

Further parameters set register stages in front of the multipliers and behind them, and an optional register at the filter input and at its output. All registers share one clock, an active-high asynchronous reset and a clock enable. A valid flag moves through a shift register whose length is the total latency. A downstream consumer therefore samples `out_sum` whenever `out_valid` is high on an enabled edge.

The latency is the sum of these terms:

- `IN_REG`;
- `MIN_PIPE`;
- `MOUT_PIPE`;
- `OUT_REG`;
- ceil(log2(`NTAPS`)), only when the registered tree is chosen.

Top module: `pfir_core`

## Requirements
- R1: While `rst` is high, `out_valid` is 0. `out_sum` is 0 whenever `in_sample` is also 0 during reset.
- R2: For each accepted sample x[n], the output equals sum over i of c[i]*x[n-i]. Here c[i] is the signed `CW`-bit field `COEFS[i*CW +: CW]` and i = 0 is the newest sample. Samples from before reset count as zero.
- R3: With `SUM_STYLE` = 0 (chain), summation adds no cycles of latency.
- R4: With `SUM_STYLE` = 1 (tree), summation adds no cycles and gives the same result as the chain.
- R5: With `SUM_STYLE` = 2 (registered tree), summation adds ceil(log2(`NTAPS`)) cycles. When a level has an odd count, its unpaired term is delayed one register so that it stays aligned with the pairs.
- R6: `MIN_PIPE` and `MOUT_PIPE` each add their own number of cycles, and zero is allowed for either.
- R7: `IN_REG` = 1 adds one cycle at the input, and `OUT_REG` = 1 adds one cycle at the output.
- R8: `out_valid` is high exactly LAT enabled edges after the edge that accepted the sample, where LAT is the sum given above. It is low for slots that carried no sample.
- R9: While `ce` is low, no register changes, and a sample offered with `in_valid` high is ignored.
- R10: A cycle with `ce` high and `in_valid` low does not shift the delay line, and its output slot has `out_valid` low.
- R11: The accumulator is `DW+CW+ceil(log2(NTAPS))` bits wide. No sum wraps, including the extreme input values -2^(DW-1) and 2^(DW-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| ce | input | 1 | Clock enable for every register |
| in_valid | input | 1 | Marks `in_sample` as a new sample |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Marks `out_sum` as a filter result |
| out_sum | output | DW+CW+ceil(log2(NTAPS)) | Signed full-precision result |

## Verification
The bench builds three copies of the filter with five taps, so that the odd-count carry occurs at two tree levels. The copies are:

- a registered tree with input, output, one pre-multiply and two post-multiply stages, giving a latency of 8;
- a combinational tree with only the output register, giving a latency of 1;
- a chain with the input register and two pre-multiply stages, giving a latency of 3.

The three copies receive the same stimulus. Together they cover every summation style, zero and non-zero pipeline depths, and both settings of each edge register. Stalls, gaps in valid, extreme values, an impulse and a reset in mid-stream then test alignment and width in every variant.

// File: rtl/pfir_pkg.sv
package pfir_pkg;

    typedef enum int {
        SUM_CHAIN    = 0,
        SUM_TREE     = 1,
        SUM_TREE_REG = 2
    } sum_style_e;

    function automatic int ceil_log2(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    // number of nodes left at tree level lvl for n leaves
    function automatic int level_count(input int n, input int lvl);
        return (n + (1 << lvl) - 1) >> lvl;
    endfunction

endpackage

// File: rtl/pfir_stage.sv
module pfir_stage #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic unused_ok;
    assign unused_ok = ^{clk, rst, ce};

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] r [DEPTH];
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) r[i] <= '0;
                end else if (ce) begin
                    r[0] <= d;
                    for (int i = 1; i < DEPTH; i++) r[i] <= r[i-1];
                end
            end
            assign q = r[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/pfir_taps.sv
module pfir_taps #(
    parameter int NTAPS = 5,
    parameter int DW    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce,
    input  logic                  shift,
    input  logic [DW-1:0]         x,
    output logic [NTAPS*DW-1:0]   taps
);
    logic unused_ok;
    assign unused_ok = ^{clk, rst, ce, shift};

    generate
        if (NTAPS == 1) begin : g_single
            assign taps = x;
        end else begin : g_line
            logic [(NTAPS-1)*DW-1:0] hist;
            // newest sample is tap 0 and is not registered here
            assign taps = {hist, x};
            always_ff @(posedge clk or posedge rst) begin
                if (rst)               hist <= '0;
                else if (ce && shift)  hist <= taps[(NTAPS-1)*DW-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/pfir_mults.sv
module pfir_mults #(
    parameter int              NTAPS     = 5,
    parameter int              DW        = 8,
    parameter int              CW        = 8,
    parameter logic [NTAPS*CW-1:0] COEFS = '0,
    parameter int              MIN_PIPE  = 0,
    parameter int              MOUT_PIPE = 0,
    localparam int             PW        = DW + CW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce,
    input  logic [NTAPS*DW-1:0]   taps,
    output logic [NTAPS*PW-1:0]   prods
);
    logic [NTAPS*DW-1:0] taps_q;
    logic [NTAPS*PW-1:0] prod_raw;

    pfir_stage #(.W(NTAPS*DW), .DEPTH(MIN_PIPE)) u_pre (
        .clk(clk), .rst(rst), .ce(ce), .d(taps), .q(taps_q)
    );

    for (genvar g = 0; g < NTAPS; g++) begin : g_mul
        logic signed [DW-1:0] a;
        logic signed [CW-1:0] b;
        logic signed [PW-1:0] p;
        assign a = taps_q[g*DW +: DW];
        assign b = COEFS[g*CW +: CW];
        assign p = a * b;
        assign prod_raw[g*PW +: PW] = p;
    end

    pfir_stage #(.W(NTAPS*PW), .DEPTH(MOUT_PIPE)) u_post (
        .clk(clk), .rst(rst), .ce(ce), .d(prod_raw), .q(prods)
    );
endmodule

// File: rtl/pfir_adder.sv
module pfir_adder
    import pfir_pkg::*;
#(
    parameter int         NTAPS = 5,
    parameter int         PW    = 16,
    parameter int         ACCW  = 19,
    parameter sum_style_e STYLE = SUM_CHAIN
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic [NTAPS*PW-1:0]     prods,
    output logic [ACCW-1:0]         sum
);
    localparam int LEVELS = ceil_log2(NTAPS);

    logic unused_ok;
    assign unused_ok = ^{clk, rst, ce};

    logic signed [ACCW-1:0] ext [NTAPS];
    for (genvar i = 0; i < NTAPS; i++) begin : g_ext
        assign ext[i] = ACCW'($signed(prods[i*PW +: PW]));
    end

    generate
        if (STYLE == SUM_CHAIN) begin : g_chain
            logic signed [ACCW-1:0] part [NTAPS];
            assign part[0] = ext[0];
            for (genvar i = 1; i < NTAPS; i++) begin : g_link
                assign part[i] = part[i-1] + ext[i];
            end
            assign sum = part[NTAPS-1];
        end else begin : g_tree
            for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
                localparam int CUR = level_count(NTAPS, l);
                logic signed [ACCW-1:0] v [CUR];
                if (l == 0) begin : g_leaf
                    for (genvar j = 0; j < CUR; j++) begin : g_j
                        assign v[j] = ext[j];
                    end
                end else begin : g_node
                    localparam int PREV = level_count(NTAPS, l - 1);
                    for (genvar j = 0; j < CUR; j++) begin : g_j
                        logic signed [ACCW-1:0] c;
                        if (2*j + 1 < PREV) begin : g_pair
                            assign c = g_lvl[l-1].v[2*j] + g_lvl[l-1].v[2*j+1];
                        end else begin : g_carry
                            assign c = g_lvl[l-1].v[2*j];
                        end
                        if (STYLE == SUM_TREE_REG) begin : g_reg
                            logic signed [ACCW-1:0] q;
                            always_ff @(posedge clk or posedge rst) begin
                                if (rst)     q <= '0;
                                else if (ce) q <= c;
                            end
                            assign v[j] = q;
                        end else begin : g_comb
                            assign v[j] = c;
                        end
                    end
                end
            end
            assign sum = g_lvl[LEVELS].v[0];
        end
    endgenerate
endmodule

// File: rtl/pfir_core.sv
module pfir_core
    import pfir_pkg::*;
#(
    parameter int              NTAPS     = 5,
    parameter int              DW        = 8,
    parameter int              CW        = 8,
    parameter logic [NTAPS*CW-1:0] COEFS = 40'h01_80_7F_F9_03,
    parameter sum_style_e      SUM_STYLE = SUM_CHAIN,
    parameter int              MIN_PIPE  = 0,
    parameter int              MOUT_PIPE = 0,
    parameter int              IN_REG    = 1,
    parameter int              OUT_REG   = 1,
    localparam int             PW        = DW + CW,
    localparam int             ACCW      = PW + ceil_log2(NTAPS),
    localparam int             TREE_LAT  = (SUM_STYLE == SUM_TREE_REG) ? ceil_log2(NTAPS) : 0,
    localparam int             LAT       = IN_REG + MIN_PIPE + MOUT_PIPE + TREE_LAT + OUT_REG
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_sample,
    output logic            out_valid,
    output logic [ACCW-1:0] out_sum
);
    logic                  v_tap;
    logic [DW-1:0]         x_tap;
    logic [NTAPS*DW-1:0]   taps;
    logic [NTAPS*PW-1:0]   prods;
    logic [ACCW-1:0]       sum_raw;

    pfir_stage #(.W(DW + 1), .DEPTH(IN_REG)) u_in_stage (
        .clk(clk), .rst(rst), .ce(ce),
        .d({in_valid, in_sample}), .q({v_tap, x_tap})
    );

    pfir_taps #(.NTAPS(NTAPS), .DW(DW)) u_taps (
        .clk(clk), .rst(rst), .ce(ce), .shift(v_tap), .x(x_tap), .taps(taps)
    );

    pfir_mults #(
        .NTAPS(NTAPS), .DW(DW), .CW(CW), .COEFS(COEFS),
        .MIN_PIPE(MIN_PIPE), .MOUT_PIPE(MOUT_PIPE)
    ) u_mults (
        .clk(clk), .rst(rst), .ce(ce), .taps(taps), .prods(prods)
    );

    pfir_adder #(.NTAPS(NTAPS), .PW(PW), .ACCW(ACCW), .STYLE(SUM_STYLE)) u_adder (
        .clk(clk), .rst(rst), .ce(ce), .prods(prods), .sum(sum_raw)
    );

    pfir_stage #(.W(ACCW), .DEPTH(OUT_REG)) u_out_stage (
        .clk(clk), .rst(rst), .ce(ce), .d(sum_raw), .q(out_sum)
    );

    // valid follows the data from the tap line to the output
    pfir_stage #(.W(1), .DEPTH(LAT - IN_REG)) u_valid_pipe (
        .clk(clk), .rst(rst), .ce(ce), .d(v_tap), .q(out_valid)
    );
endmodule

// File: rtl/pfir_core_chk.sv
module pfir_core_chk #(
    parameter int              NTAPS = 5,
    parameter int              DW    = 8,
    parameter int              CW    = 8,
    parameter logic [NTAPS*CW-1:0] COEFS = '0,
    parameter int              ACCW  = 19,
    parameter int              LAT   = 1
) (
    input logic            clk,
    input logic            rst,
    input logic            ce,
    input logic            in_valid,
    input logic            out_valid,
    input logic [ACCW-1:0] out_sum
);
    function automatic longint peak_mag();
        longint s;
        longint c;
        s = 0;
        for (int i = 0; i < NTAPS; i++) begin
            c = longint'($signed(COEFS[i*CW +: CW]));
            s += (c < 0) ? -c : c;
        end
        return s * (longint'(1) << (DW - 1));
    endfunction

    localparam longint BOUND = peak_mag();

    int in_cnt;
    int out_cnt;
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            in_cnt  <= 0;
            out_cnt <= 0;
        end else if (ce) begin
            if (in_valid)  in_cnt  <= in_cnt + 1;
            if (out_valid) out_cnt <= out_cnt + 1;
        end
    end

    // R1: no result is flagged during reset
    always @(posedge clk) begin
        if (rst) a_r1_idle_in_reset: assert (!out_valid);
    end

    // R8: never more results than accepted samples
    a_r8_no_orphan: assert property (@(posedge clk) disable iff (rst)
        out_cnt <= in_cnt);

    // R8: samples in flight never exceed the latency
    a_r8_flight_bound: assert property (@(posedge clk) disable iff (rst)
        (in_cnt - out_cnt) <= LAT);

    // R11: a flagged result lies inside the reachable range
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'($signed(out_sum)) <= BOUND &&
                       longint'($signed(out_sum)) >= -BOUND));

    generate
        if (LAT > 0) begin : g_hold
            // R9: a disabled edge leaves the valid flag alone
            a_r9_hold_valid: assert property (@(posedge clk) disable iff (rst)
                !ce |=> $stable(out_valid));
        end
    endgenerate
endmodule

bind pfir_core pfir_core_chk #(
    .NTAPS(NTAPS), .DW(DW), .CW(CW), .COEFS(COEFS), .ACCW(ACCW), .LAT(LAT)
) u_chk (
    .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid),
    .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/pfir_core_bench.sv
module pfir_core_bench;
    localparam int         NT      = 5;
    localparam int         DW      = 8;
    localparam int         CW      = 8;
    localparam logic [39:0] CF     = 40'h01_80_7F_F9_03;
    localparam int         ACCW    = 19;
    localparam int         TOL_LSB = 0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b1;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;

    logic            ov_a, ov_b, ov_c;
    logic [ACCW-1:0] os_a, os_b, os_c;

    always #4 clk = ~clk;

    // R5 R6 R7: registered tree, latency 1+1+2+3+1
    pfir_core #(.COEFS(CF), .SUM_STYLE(pfir_pkg::SUM_TREE_REG),
        .MIN_PIPE(1), .MOUT_PIPE(2), .IN_REG(1), .OUT_REG(1)) u_pfir_core (
        .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(ov_a), .out_sum(os_a));

    // R4 R7: combinational tree, latency 1
    pfir_core #(.COEFS(CF), .SUM_STYLE(pfir_pkg::SUM_TREE),
        .MIN_PIPE(0), .MOUT_PIPE(0), .IN_REG(0), .OUT_REG(1)) u_pfir_core_tree (
        .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(ov_b), .out_sum(os_b));

    // R3 R6 R7: chain, latency 1+2
    pfir_core #(.COEFS(CF), .SUM_STYLE(pfir_pkg::SUM_CHAIN),
        .MIN_PIPE(2), .MOUT_PIPE(0), .IN_REG(1), .OUT_REG(0)) u_pfir_core_chain (
        .clk(clk), .rst(rst), .ce(ce), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(ov_c), .out_sum(os_c));

    function automatic int clog(input int v);
        int r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    int     coef [NT] = '{3, -7, 127, -128, 1};
    int     lat  [3];
    string  sumtag [3] = '{"R5", "R4", "R3"};
    longint hist [NT];
    bit     pv [3][16];
    longint ps [3][16];
    int     vectors = 0;
    int     miscompares = 0;
    string  phase_tag = "R1";
    bit     done = 1'b0;
    bit     ov [3];
    longint os [3];

    initial begin
        lat[0] = 1 + 1 + 2 + clog(NT) + 1;
        lat[1] = 0 + 0 + 0 + 0 + 1;
        lat[2] = 1 + 2 + 0 + 0 + 0;
    end

    always_comb begin
        ov[0] = ov_a; os[0] = longint'($signed(os_a));
        ov[1] = ov_b; os[1] = longint'($signed(os_b));
        ov[2] = ov_c; os[2] = longint'($signed(os_c));
    end

    // reference model: convolution over accepted samples, delayed per copy
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NT; i++) hist[i] = 0;
            for (int k = 0; k < 3; k++)
                for (int i = 0; i < 16; i++) begin pv[k][i] = 0; ps[k][i] = 0; end
        end else if (ce) begin
            longint y;
            y = 0;
            if (in_valid) begin
                for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = longint'($signed(in_sample));
                for (int i = 0; i < NT; i++) y += coef[i] * hist[i];
            end
            for (int k = 0; k < 3; k++) begin
                for (int i = 15; i > 0; i--) begin
                    pv[k][i] = pv[k][i-1];
                    ps[k][i] = ps[k][i-1];
                end
                pv[k][0] = in_valid;
                ps[k][0] = y;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int inst,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s (phase %s) copy %0d: actual %0d expected %0d",
                     tag, phase_tag, inst, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            for (int k = 0; k < 3; k++) begin
                if (rst) begin
                    chk(ov[k] == 1'b0, "R1 valid", k, longint'(ov[k]), 0);
                    chk(os[k] == 0, "R1 sum", k, os[k], 0);
                end else begin
                    bit ev;
                    ev = pv[k][lat[k]-1];
                    chk(ov[k] == ev, "R8 valid timing", k, longint'(ov[k]), longint'(ev));
                    if (ev && ov[k]) begin
                        longint d;
                        d = os[k] - ps[k][lat[k]-1];
                        if (d < 0) d = -d;
                        chk(d <= TOL_LSB, {"R2 sum ", sumtag[k]}, k, os[k], ps[k][lat[k]-1]);
                    end
                end
            end
        end
    end

    task automatic drive(input bit v, input bit e, input logic [DW-1:0] s);
        @(posedge clk);
        #1;
        in_valid  = v;
        ce        = e;
        in_sample = s;
    endtask

    int seed = 32'h1234_5678;
    function automatic logic [7:0] rnd();
        seed = seed * 1103515245 + 12345;
        return seed[23:16];
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        phase_tag = "R2";
        for (int i = 0; i < 30; i++) drive(1, 1, rnd());

        phase_tag = "R2 impulse";
        drive(1, 1, 8'd1);
        for (int i = 0; i < 10; i++) drive(1, 1, 8'd0);

        phase_tag = "R9";
        for (int i = 0; i < 40; i++) begin
            logic [7:0] r;
            r = rnd();
            drive(1, r[0] | r[3], rnd());
        end

        phase_tag = "R10";
        for (int i = 0; i < 40; i++) begin
            logic [7:0] r;
            r = rnd();
            drive(r[1], 1, rnd());
        end

        phase_tag = "R11";
        for (int i = 0; i < 12; i++) drive(1, 1, 8'h80);
        for (int i = 0; i < 12; i++) drive(1, 1, (i % 2) ? 8'h7F : 8'h80);
        for (int i = 0; i < 8; i++) drive(1, 1, 8'h7F);

        phase_tag = "R1 mid-run";
        drive(1, 1, 8'd0);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 20; i++) drive(1, 1, rnd());

        phase_tag = "drain";
        for (int i = 0; i < 20; i++) drive(0, 1, 8'd0);

        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule